// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction Processor Core

This block is a 32-bit processor core in which every instruction completes within one clock period. On each cycle the program counter addresses an instruction memory. The returned word is decoded. Operands are read from a 32-entry register file and combined in a single shared ALU. Results are then written back to a register or to a data memory, and the next program counter is chosen for the following edge.

The core executes nine instructions: add, sub, and, or, slt, lw, sw, beq and j. The ALU serves three purposes: arithmetic and logic for register-to-register operations, base-plus-offset address formation for loads and stores, and the equality test for branches. Two dedicated adders form the sequential address and the branch target.

Both memories sit outside the core. The instruction port is an address output with a word input. The data port has an address, write data, a write strobe and a combinational read-data input. Writes to the data memory take effect on the rising clock edge while the strobe is high.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter (`imem_addr`) to 0, and `dmem_we` is low while the reset instruction at address 0 is not a store. Every instruction other than a taken beq or a j advances the program counter by 4.
- R2: Instructions with opcode field [31:26] = 000000 read registers rs [25:21] and rt [20:16] and write register rd [15:11]. The operation is chosen by funct [5:0]: 100000 computes rs+rt, 100010 computes rs-rt, 100100 computes the bitwise AND, and 100101 computes the bitwise OR.
- R3: Funct 101010 writes 1 to rd when rs is less than rt as a signed two's-complement number, and writes 0 otherwise.
- R4: Writes that target register 0 are discarded, so register 0 always reads as zero.
- R5: lw (opcode 100011) drives `dmem_addr` with rs plus the sign-extended 16-bit immediate [15:0], and writes `dmem_rdata` into register rt.
- R6: sw (opcode 101011) drives `dmem_we` high, drives `dmem_addr` with rs plus the sign-extended immediate, and drives `dmem_wdata` with register rt. `dmem_we` is low for every other instruction.
- R7: beq (opcode 000100) loads PC+4 plus (sign-extended immediate shifted left by 2) when rs equals rt. Otherwise it loads PC+4.
- R8: j (opcode 000010) loads {PC+4[31:28], instr[25:0], 2'b00}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction address (program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (register rt) |
| dmem_we | output | 1 | Store strobe, write happens on the rising edge |
| dmem_rdata | input | 32 | Load data at dmem_addr, combinational |

## Verification
The assertions assume that `imem_rdata` and `dmem_rdata` settle combinationally from the current addresses within the cycle. They also assume that the instruction word carries one of the nine encodings. An unknown opcode acts as a no-op, so the sequential-PC property still holds for it. The stimulus uses word-aligned addresses and memories that the bench models as arrays answering in the same cycle. The program contains only the nine instructions, and it stops in a jump-to-self loop so that the fetch address never leaves the modelled range.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN  = 32;
    localparam int NREG  = 32;
    localparam int RAW   = $clog2(NREG);

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_J     = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        ALUOP_ADD   = 2'b00,
        ALUOP_SUB   = 2'b01,
        ALUOP_FUNCT = 2'b10
    } aluop_e;

    typedef enum logic [2:0] {
        ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT
    } alu_fn_e;

    typedef struct packed {
        logic   reg_write;
        logic   dst_is_rd;
        logic   src_is_imm;
        logic   mem_write;
        logic   load_to_reg;
        logic   branch;
        logic   jump;
        aluop_e aluop;
    } ctrl_t;

    function automatic alu_fn_e alu_select(input aluop_e op, input logic [5:0] funct);
        alu_fn_e fn;
        fn = ALU_ADD;
        case (op)
            ALUOP_SUB: fn = ALU_SUB;
            ALUOP_FUNCT: begin
                case (funct)
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn = ALU_ADD;
                endcase
            end
            default: fn = ALU_ADD;
        endcase
        return fn;
    endfunction

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{reg_write: 1'b0, dst_is_rd: 1'b0, src_is_imm: 1'b0, mem_write: 1'b0,
                 load_to_reg: 1'b0, branch: 1'b0, jump: 1'b0, aluop: ALUOP_ADD};
        case (opcode)
            OP_RTYPE: begin
                ctrl.reg_write = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.aluop     = ALUOP_FUNCT;
            end
            OP_LW: begin
                ctrl.reg_write   = 1'b1;
                ctrl.src_is_imm  = 1'b1;
                ctrl.load_to_reg = 1'b1;
            end
            OP_SW: begin
                ctrl.src_is_imm = 1'b1;
                ctrl.mem_write  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.aluop  = ALUOP_SUB;
            end
            OP_J:    ctrl.jump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = NREG,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

    // R2 / R5: a write to a nonzero register is visible on the next cycle
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));

    // R4: register 0 never changes from zero
    assert_r0_zero_R4: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);
    logic [XLEN-1:0] pc, pc_plus4, pc_next, br_target, jmp_target;
    logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, wb_data;
    logic [RAW-1:0]  wr_addr;
    logic            alu_zero, take_br;
    ctrl_t           ctrl;
    alu_fn_e         alu_fn;

    sc_decoder u_dec (.opcode(imem_rdata[31:26]), .ctrl(ctrl));

    assign imm_ext    = sext16(imem_rdata[15:0]);
    assign wr_addr    = ctrl.dst_is_rd ? imem_rdata[15:11] : imem_rdata[20:16];
    assign alu_b      = ctrl.src_is_imm ? imm_ext : rt_val;
    assign alu_fn     = alu_select(ctrl.aluop, imem_rdata[5:0]);
    assign wb_data    = ctrl.load_to_reg ? dmem_rdata : alu_y;

    sc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk(clk), .rst(rst),
        .ra_a(imem_rdata[25:21]), .ra_b(imem_rdata[20:16]),
        .rd_a(rs_val), .rd_b(rt_val),
        .we(ctrl.reg_write), .wa(wr_addr), .wd(wb_data)
    );

    sc_alu #(.W(XLEN)) u_alu (.a(rs_val), .b(alu_b), .fn(alu_fn), .y(alu_y), .zero(alu_zero));

    assign pc_plus4   = pc + 32'd4;
    assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], imem_rdata[25:0], 2'b00};
    assign take_br    = ctrl.branch & alu_zero;

    always_comb begin
        if (ctrl.jump)    pc_next = jmp_target;
        else if (take_br) pc_next = br_target;
        else              pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    assign imem_addr  = pc;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_write;

    // R1: straight-line instructions step the PC by one word
    assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[31:26] != OP_BEQ && imem_rdata[31:26] != OP_J) |=> (pc == $past(pc) + 32'd4));

    // R6: the store strobe only accompanies the store opcode
    assert_store_only_R6: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (imem_rdata[31:26] == OP_SW));

    // R7: equal operands redirect to the offset target
    assert_beq_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[31:26] == OP_BEQ && rs_val == rt_val) |=>
        (pc == $past(pc) + 32'd4 + {$past(imem_rdata[29:0]) & 30'h0000_FFFF
                                    | {30{$past(imem_rdata[15])}} & 30'h3FFF_0000, 2'b00}));

    // R7: unequal operands fall through
    assert_beq_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[31:26] == OP_BEQ && rs_val != rt_val) |=> (pc == $past(pc) + 32'd4));

    // R8: a jump lands on the word index carried in the instruction
    assert_jump_index_R8: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[31:26] == OP_J) |=> (pc[27:0] == {$past(imem_rdata[25:0]), 2'b00}));
endmodule

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sc_core dut (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(input int idx);
        return {6'b000010, idx[25:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    localparam logic [31:0] VA = 32'd5;
    localparam logic [31:0] VB = 32'hFFFF_FFFD;
    localparam logic [31:0] VC = 32'h0F0F_0F00;
    localparam logic [31:0] UNTOUCHED = 32'h0000_AAAA;

    logic [31:0] st_data [8];
    logic [31:0] st_addr [8];

    task automatic load_program();
        for (int i = 0; i < 64; i++) begin imem[i] = 32'd0; dmem[i] = UNTOUCHED; end
        dmem[0] = VA; dmem[1] = VB; dmem[2] = VC; dmem[10] = 32'hDEAD_BEEF;
        imem[0]  = enc_i(6'b100011, 1, 0, 0);
        imem[1]  = enc_i(6'b100011, 2, 0, 4);
        imem[2]  = enc_i(6'b100011, 3, 0, 8);
        imem[3]  = enc_r(6'b100000, 4, 1, 2);
        imem[4]  = enc_r(6'b100010, 5, 1, 2);
        imem[5]  = enc_r(6'b100100, 6, 3, 2);
        imem[6]  = enc_r(6'b100101, 7, 3, 1);
        imem[7]  = enc_r(6'b101010, 8, 2, 1);
        imem[8]  = enc_r(6'b101010, 9, 1, 2);
        imem[9]  = enc_r(6'b100000, 0, 1, 1);
        imem[10] = enc_i(6'b101011, 4, 0, 16);
        imem[11] = enc_i(6'b101011, 5, 0, 20);
        imem[12] = enc_i(6'b101011, 6, 0, 24);
        imem[13] = enc_i(6'b101011, 7, 0, 28);
        imem[14] = enc_i(6'b101011, 8, 0, 32);
        imem[15] = enc_i(6'b101011, 9, 0, 36);
        imem[16] = enc_i(6'b101011, 0, 0, 40);
        imem[17] = enc_i(6'b101011, 1, 5, -4);
        imem[18] = enc_i(6'b000100, 2, 1, 2);
        imem[19] = enc_i(6'b000100, 1, 1, 2);
        imem[20] = enc_i(6'b101011, 1, 0, 44);
        imem[21] = enc_i(6'b101011, 1, 0, 44);
        imem[22] = enc_j(25);
        imem[23] = enc_i(6'b101011, 1, 0, 48);
        imem[24] = enc_i(6'b101011, 1, 0, 48);
        imem[25] = enc_j(25);
        st_data[0] = VA + VB; st_data[1] = VA - VB; st_data[2] = VC & VB; st_data[3] = VC | VA;
        st_data[4] = ($signed(VB) < $signed(VA)) ? 32'd1 : 32'd0;
        st_data[5] = ($signed(VA) < $signed(VB)) ? 32'd1 : 32'd0;
        st_data[6] = 32'd0; st_data[7] = VA;
        for (int k = 0; k < 7; k++) st_addr[k] = 32'd16 + 32'(4 * k);
        st_addr[7] = (VA - VB) - 32'd4;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(imem_addr == 32'd0, "R1 reset pc", imem_addr, 32'd0);
        chk(dmem_we == 1'b0, "R1 reset store strobe", {31'd0, dmem_we}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_straight_line();
        for (int i = 0; i < 18; i++) begin
            chk(imem_addr == 32'(4 * i), "R1 sequential pc", imem_addr, 32'(4 * i));
            if (i >= 10) begin
                chk(dmem_we == 1'b1, "R6 store strobe", {31'd0, dmem_we}, 32'd1);
                chk(dmem_addr == st_addr[i-10], "R6 store address", dmem_addr, st_addr[i-10]);
                chk(dmem_wdata == st_data[i-10], "R6 store data (R2 R3 R4 R5 results)", dmem_wdata, st_data[i-10]);
            end else begin
                chk(dmem_we == 1'b0, "R6 no strobe for non-store", {31'd0, dmem_we}, 32'd0);
            end
            if (i < 3)
                chk(dmem_addr == 32'(4 * i), "R5 load address", dmem_addr, 32'(4 * i));
            @(negedge clk);
        end
    endtask

    task automatic t_branch();
        chk(imem_addr == 32'd72, "R7 at first beq", imem_addr, 32'd72);
        chk(dmem_we == 1'b0, "R6 no strobe on beq", {31'd0, dmem_we}, 32'd0);
        @(negedge clk);
        chk(imem_addr == 32'd76, "R7 beq not taken", imem_addr, 32'd76);
        @(negedge clk);
        chk(imem_addr == 32'd88, "R7 beq taken", imem_addr, 32'd88);
    endtask

    task automatic t_jump();
        @(negedge clk);
        chk(imem_addr == 32'd100, "R8 jump target", imem_addr, 32'd100);
        @(negedge clk);
        chk(imem_addr == 32'd100, "R8 jump to self", imem_addr, 32'd100);
    endtask

    task automatic t_memory();
        chk(dmem[4] == st_data[0], "R2 add result", dmem[4], st_data[0]);
        chk(dmem[5] == st_data[1], "R2 sub result", dmem[5], st_data[1]);
        chk(dmem[6] == st_data[2], "R2 and result", dmem[6], st_data[2]);
        chk(dmem[7] == st_data[3], "R2 or result", dmem[7], st_data[3]);
        chk(dmem[8] == 32'd1, "R3 slt negative less", dmem[8], 32'd1);
        chk(dmem[9] == 32'd0, "R3 slt not less", dmem[9], 32'd0);
        chk(dmem[10] == 32'd0, "R4 register 0 reads zero", dmem[10], 32'd0);
        chk(dmem[1] == VA, "R5 negative offset store", dmem[1], VA);
        chk(dmem[11] == UNTOUCHED, "R7 skipped by branch", dmem[11], UNTOUCHED);
        chk(dmem[12] == UNTOUCHED, "R8 skipped by jump", dmem[12], UNTOUCHED);
    endtask

    task automatic t_reset_again();
        rst = 1'b1;
        @(negedge clk);
        chk(imem_addr == 32'd0, "R1 mid-run reset pc", imem_addr, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(imem_addr == 32'd4, "R1 restart steps", imem_addr, 32'd4);
    endtask

    initial begin
        load_program();
        t_reset();
        t_straight_line();
        t_branch();
        t_jump();
        t_memory();
        t_reset_again();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule